// File: doc/BRIEF.md
# Power-State Wake and Interrupt Controller

This block sits between a host-facing power-management function and an embedded processor. It watches two externally driven lines: one carries the inverted high bit of the function's 2-bit power state, and the other carries both the inverted low bit and the power-management-event enable level. It turns edges on those lines into processor interrupts and wake events. A drop of the high line means the host is powering the function down. A return of that line, or any toggle of the event-enable level while a local enable bit is set, wakes the processor.

Each cause latches a sticky status bit that firmware clears by writing ones. The interrupt output is the OR of the status bits after a per-cause mask. Firmware can raise a request to the host, which any wake event withdraws. While the event-enable level is low, firmware can also raise a full-shutdown request. All inputs pass through a parameterised synchroniser chain before edge detection.

Top module: `pwr_wake_ctl`

## Requirements
- R1: After reset, `status`, `irq`, `wake`, `pm_req` and `full_off_req` are all 0, and `pwr_state` reads 2'b01 while `ps_hi_n` is 1 and `ps_lo_evt` is 0.
- R2: A falling edge on `ps_hi_n` sets `status[0]` (power-down cause) on the third rising clock edge after the pin changes. It does not pulse `wake`.
- R3: A rising edge on `ps_hi_n` sets `status[1]` (power-up cause) and drives `wake` high for exactly one cycle. Both appear on the third rising clock edge after the pin changes.
- R4: When `evt_irq_en` is 1, a rising or falling edge on `ps_lo_evt` sets `status[2]` (event cause) and pulses `wake` for one cycle, with the same latency as R3. When `evt_irq_en` is 0, such edges change neither `status[2]` nor `wake`.
- R5: Status bits are sticky. A cycle with `fw_clr_stb` high clears every bit whose `fw_clr_mask` bit is 1 and leaves the others as they are. If a bit is set and cleared in the same cycle, the set wins.
- R6: `irq` equals the OR over i of `status[i] & irq_mask[i]`, with bit order 0 = power-down, 1 = power-up, 2 = event.
- R7: `pm_req` goes to 1 on the edge after `fw_pmreq_set` is high. It goes to 0 on the edge after `fw_pmreq_clr` is high or on the edge where `wake` rises. Clearing wins over setting.
- R8: `full_off_req` goes to 1 on the edge after `fw_off_set` is high, but only while the synchronised `ps_lo_evt` level is 0. It goes to 0 when that level is 1 or after `fw_off_clr` is high. A set request made while the level is 1 has no effect.
- R9: `pwr_state` is the bitwise inverse of the synchronised pins, with bit 1 = ~`ps_hi_n` and bit 0 = ~`ps_lo_evt`, and it follows a pin change within three clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ps_hi_n | input | 1 | Inverted high bit of the power state |
| ps_lo_evt | input | 1 | Inverted low bit of the power state, also the event-enable level |
| evt_irq_en | input | 1 | Enables interrupt and wake on event-enable changes |
| irq_mask | input | 3 | Per-cause interrupt enable |
| fw_clr_stb | input | 1 | Write-one-to-clear strobe for status |
| fw_clr_mask | input | 3 | Status bits to clear |
| fw_pmreq_set | input | 1 | Firmware request to raise `pm_req` |
| fw_pmreq_clr | input | 1 | Firmware request to drop `pm_req` |
| fw_off_set | input | 1 | Firmware request for full shutdown |
| fw_off_clr | input | 1 | Firmware withdrawal of full shutdown |
| irq | output | 1 | Processor interrupt |
| wake | output | 1 | One-cycle wake pulse |
| status | output | 3 | Sticky cause bits |
| pwr_state | output | 2 | Synchronised power state |
| pm_req | output | 1 | Power-management request to the host |
| full_off_req | output | 1 | Full-shutdown request |

## Verification
The assertions assume that the firmware strobes are synchronous to `clk` and that the pin inputs are asynchronous but are held steady long enough for the synchroniser to resolve. They also assume that the pins are at their reset levels while reset is asserted, so that no edge is seen when reset is released. The stimulus drives every input one time unit after a rising edge and holds the pins for several cycles between changes. The sweep walks all sixteen pin transitions with the event enable both off and on, and every case lets its effects settle before status is cleared for the next case.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
   localparam int NCAUSE    = 3;
   localparam int CAUSE_PDN = 0;
   localparam int CAUSE_PUP = 1;
   localparam int CAUSE_EVT = 2;
   localparam int PIN_HI    = 0;
   localparam int PIN_EVT   = 1;
endpackage

// File: rtl/pwc_sync.sv
module pwc_sync #(
   parameter int          W      = 2,
   parameter int          STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   initial begin
      assert (STAGES >= 2) else $error("pwc_sync needs at least two stages");
      assert (W >= 1) else $error("pwc_sync width must be positive");
   end

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pwc_edge.sv
module pwc_edge #(
   parameter int           W       = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= lvl;

   assign rise = lvl & ~prev_q;
   assign fall = ~lvl & prev_q;
endmodule

// File: rtl/pwc_status.sv
module pwc_status #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_vec,
   input  logic         clr_stb,
   input  logic [N-1:0] clr_mask,
   output logic [N-1:0] st
);
   initial assert (N >= 1) else $error("pwc_status needs at least one cause");

   genvar i;
   generate
      for (i = 0; i < N; i++) begin : g_bit
         logic clr_i;
         assign clr_i = clr_stb & clr_mask[i];

         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n)          st[i] <= 1'b0;
            else if (set_vec[i]) st[i] <= 1'b1;
            else if (clr_i)      st[i] <= 1'b0;

         assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> st[i]);
         assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !set_vec[i]) |=> !st[i]);
         assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (st[i] && !clr_i) |=> st[i]);
      end
   endgenerate
endmodule

// File: rtl/pwr_wake_ctl.sv
module pwr_wake_ctl
   import pwc_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit HI_RST      = 1'b1,
   parameter bit EVT_RST     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ps_hi_n,
   input  logic              ps_lo_evt,
   input  logic              evt_irq_en,
   input  logic [NCAUSE-1:0] irq_mask,
   input  logic              fw_clr_stb,
   input  logic [NCAUSE-1:0] fw_clr_mask,
   input  logic              fw_pmreq_set,
   input  logic              fw_pmreq_clr,
   input  logic              fw_off_set,
   input  logic              fw_off_clr,
   output logic              irq,
   output logic              wake,
   output logic [NCAUSE-1:0] status,
   output logic [1:0]        pwr_state,
   output logic              pm_req,
   output logic              full_off_req
);
   localparam logic [1:0] PIN_RST = {EVT_RST, HI_RST};

   logic [1:0]        pin_raw, pin_s, pin_rise, pin_fall;
   logic [NCAUSE-1:0] cause;
   logic              wake_d, evt_lvl;

   initial assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");

   assign pin_raw[PIN_HI]  = ps_hi_n;
   assign pin_raw[PIN_EVT] = ps_lo_evt;

   pwc_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(pin_s));

   pwc_edge #(.W(2), .RST_VAL(PIN_RST)) u_edge (
      .clk(clk), .rst_n(rst_n), .lvl(pin_s), .rise(pin_rise), .fall(pin_fall));

   assign evt_lvl          = pin_s[PIN_EVT];
   assign cause[CAUSE_PDN] = pin_fall[PIN_HI];
   assign cause[CAUSE_PUP] = pin_rise[PIN_HI];
   assign cause[CAUSE_EVT] = evt_irq_en & (pin_rise[PIN_EVT] | pin_fall[PIN_EVT]);
   assign wake_d           = cause[CAUSE_PUP] | cause[CAUSE_EVT];

   pwc_status #(.N(NCAUSE)) u_status (
      .clk(clk), .rst_n(rst_n), .set_vec(cause),
      .clr_stb(fw_clr_stb), .clr_mask(fw_clr_mask), .st(status));

   assign irq       = |(status & irq_mask);
   assign pwr_state = {~pin_s[PIN_HI], ~pin_s[PIN_EVT]};

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) wake <= 1'b0;
      else        wake <= wake_d;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                     pm_req <= 1'b0;
      else if (wake_d || fw_pmreq_clr) pm_req <= 1'b0;
      else if (fw_pmreq_set)          pm_req <= 1'b1;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                      full_off_req <= 1'b0;
      else if (evt_lvl || fw_off_clr)  full_off_req <= 1'b0;
      else if (fw_off_set)             full_off_req <= 1'b1;

   assert_pup_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pin_s[PIN_HI]) |=> wake);
   assert_pdn_nowake_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_fall[PIN_HI] && !cause[CAUSE_EVT]) |=> !wake);
   assert_evt_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt_irq_en && !pin_rise[PIN_HI]) |=> !wake);
   assert_pmreq_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake) |-> !pm_req);
   assert_off_evt_R8: assert property (@(posedge clk) disable iff (!rst_n)
      evt_lvl |=> !full_off_req);
   assert_irq_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (status == '0) |-> !irq);
endmodule

// File: tb/pwr_wake_ctl_tb_top.sv
module pwr_wake_ctl_tb_top;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ps_hi_n = 1'b1, ps_lo_evt = 1'b0, evt_irq_en = 1'b0;
   logic [2:0] irq_mask = 3'b000, fw_clr_mask = 3'b000;
   logic fw_clr_stb = 0, fw_pmreq_set = 0, fw_pmreq_clr = 0, fw_off_set = 0, fw_off_clr = 0;
   logic irq, wake, pm_req, full_off_req;
   logic [2:0] status;
   logic [1:0] pwr_state;
   int total = 0, bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwr_wake_ctl dut_i (
      .clk(clk), .rst_n(rst_n), .ps_hi_n(ps_hi_n), .ps_lo_evt(ps_lo_evt),
      .evt_irq_en(evt_irq_en), .irq_mask(irq_mask), .fw_clr_stb(fw_clr_stb),
      .fw_clr_mask(fw_clr_mask), .fw_pmreq_set(fw_pmreq_set), .fw_pmreq_clr(fw_pmreq_clr),
      .fw_off_set(fw_off_set), .fw_off_clr(fw_off_clr), .irq(irq), .wake(wake),
      .status(status), .pwr_state(pwr_state), .pm_req(pm_req), .full_off_req(full_off_req));

   task automatic tick(int n = 1);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_all();
      fw_clr_stb = 1; fw_clr_mask = 3'b111; tick(); fw_clr_stb = 0; fw_clr_mask = 3'b000;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      irq_mask = 3'b111;
      tick(3); rst_n = 1; tick();
      chk("R1 status", status, 0);
      chk("R1 irq", irq, 0);
      chk("R1 wake", wake, 0);
      chk("R1 pm_req", pm_req, 0);
      chk("R1 full_off_req", full_off_req, 0);
      chk("R1 pwr_state", pwr_state, 1);

      // Sweep: R2 R3 R4 R6 R9 over every pin transition, event enable off and on
      for (int en = 0; en < 2; en++)
         for (int f = 0; f < 4; f++)
            for (int t = 0; t < 4; t++) begin
               int e_pdn, e_pup, e_evt, e_st;
               evt_irq_en = en[0];
               ps_hi_n = f[1]; ps_lo_evt = f[0];
               tick(4); clear_all(); tick();
               chk("R5 cleared", status, 0);
               ps_hi_n = t[1]; ps_lo_evt = t[0];
               tick(2);
               chk("R3 wake latency", wake, 0);
               tick();
               e_pdn = (f[1] && !t[1]) ? 1 : 0;
               e_pup = (!f[1] && t[1]) ? 1 : 0;
               e_evt = (en == 1 && f[0] != t[0]) ? 1 : 0;
               e_st  = e_pdn + 2*e_pup + 4*e_evt;
               chk("R2/R3/R4 status", status, e_st);
               chk("R3/R4 wake", wake, e_pup | e_evt);
               chk("R9 pwr_state", pwr_state, (~t) & 3);
               tick();
               chk("R3 wake one cycle", wake, 0);
               chk("R5 sticky", status, e_st);
               for (int m = 0; m < 8; m++) begin
                  irq_mask = m[2:0]; #1;
                  chk("R6 irq", irq, ((e_st & m) != 0) ? 1 : 0);
               end
               irq_mask = 3'b111;
            end

      // R5: partial clear and set-wins
      evt_irq_en = 1; ps_hi_n = 1; ps_lo_evt = 0; tick(4); clear_all();
      ps_hi_n = 0; tick(4); ps_hi_n = 1; tick(4); ps_lo_evt = 1; tick(4);
      chk("R5 all set", status, 7);
      fw_clr_stb = 1; fw_clr_mask = 3'b101; tick(); fw_clr_stb = 0; fw_clr_mask = 0;
      chk("R5 partial w1c", status, 2);
      clear_all();
      ps_hi_n = 0; tick(2);
      fw_clr_stb = 1; fw_clr_mask = 3'b111; tick(); fw_clr_stb = 0; fw_clr_mask = 0;
      chk("R5 set wins", status, 1);

      // R7: pm_req
      fw_pmreq_set = 1; tick(); fw_pmreq_set = 0;
      chk("R7 set", pm_req, 1);
      fw_pmreq_clr = 1; tick(); fw_pmreq_clr = 0;
      chk("R7 fw clear", pm_req, 0);
      fw_pmreq_set = 1; fw_pmreq_clr = 1; tick(); fw_pmreq_set = 0; fw_pmreq_clr = 0;
      chk("R7 clear wins", pm_req, 0);
      fw_pmreq_set = 1; tick(); fw_pmreq_set = 0;
      evt_irq_en = 0; ps_lo_evt = 0; tick(4);
      chk("R7 gated event keeps", pm_req, 1);
      ps_hi_n = 1; tick(2);
      chk("R7 before wake", pm_req, 1);
      tick();
      chk("R7 wake clears", pm_req, 0);

      // R8: full shutdown request
      ps_lo_evt = 0; tick(4);
      fw_off_set = 1; tick(); fw_off_set = 0;
      chk("R8 set while low", full_off_req, 1);
      ps_lo_evt = 1; tick(2);
      chk("R8 before drop", full_off_req, 1);
      tick();
      chk("R8 level drops", full_off_req, 0);
      fw_off_set = 1; tick(); fw_off_set = 0; tick();
      chk("R8 set ignored while high", full_off_req, 0);
      ps_lo_evt = 0; tick(4);
      fw_off_set = 1; tick(); fw_off_set = 0;
      fw_off_clr = 1; tick(); fw_off_clr = 0;
      chk("R8 fw clear", full_off_req, 0);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule